// File: doc/BRIEF.md
# Timer Burst Access Window

This block is the register-file front end of a timer peripheral. It offers a single word-wide window register. Reads and writes to that window land on a run of consecutive timer registers instead of on the window itself. A DMA engine can therefore fill or dump several timer registers in one burst while always addressing the same location. A configuration register gives the first register of the run and the length of the run. A hardware transfer index then walks the run one register per window access, and wraps at the end of the run so that the next burst starts again at the first register.

The block contains a small stub bank of 16-bit target registers, so the redirection can be observed directly. Read data is registered and appears one cycle after the request.

Top module: `tmr_burst_win`

## Requirements
- R1: After reset the window configuration, the transfer index, every stub register and the read response are all zero, and a read of any mapped register returns 0.
- R2: The configuration register sits at byte address 0x48. Its first-register index occupies bits 4:0 and its last-transfer index occupies bits 12:8. Every other bit is ignored on write and reads as zero.
- R3: A full-word access to the window at byte address 0x4C reaches the stub register whose word index is the first-register index plus the transfer index. That register's byte address is therefore 4 × (first + index).
- R4: Each accepted window access, read or write, moves the transfer index up by one. The access made while the index equals the last-transfer index returns the index to 0.
- R5: A write to the configuration register sets the transfer index to 0.
- R6: A window access is accepted only with size code 2 (word; code 0 is byte, code 1 is halfword) and address bits 1:0 equal to 0. A rejected window access leaves the index and every register unchanged, and a rejected read returns 0.
- R7: A redirected read returns the target's 16-bit value with bits 31:16 zero. A redirected write stores only bits 15:0 of the write data.
- R8: When the redirected word index is 18 or more (the configuration register, the window itself, or past the stub bank), a read returns 0 and a write is dropped, yet the index still advances and wraps as in R4.
- R9: Stub register i (0 to 17) is reached directly at byte address 4 × i. There it reads and writes bits 15:0 and reads zero in bits 31:16.
- R10: For every read request, bus_rvalid is high in the following cycle together with its data. It is low after writes and idle cycles. A read of an unmapped address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Request strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe, one cycle after a read |

## Verification
The two functions that can coincide are the end-of-run wrap of the transfer index and the dropping of an out-of-range redirection. They coincide when the first-register index plus the last-transfer index points past the stub bank. The bench provokes this twice: once with a run of 16 + 0..4, and once with a run of 31 + 0..31 in which every target is out of range. It judges each access against its behavioural model. Reads must return zero, the configuration register and the stubs must read back untouched, and the burst that follows must restart at the first register. This confirms that the wrap happened even though nothing was written.

// File: rtl/tbw_pkg.sv
`timescale 1ns/1ps
package tbw_pkg;
    // default geometry of the window and its target bank
    localparam int DEF_ADDR_W   = 8;
    localparam int DEF_DATA_W   = 32;
    localparam int DEF_TGT_W    = 16;
    localparam int DEF_IDX_W    = 5;
    localparam int DEF_NUM_STUB = 18;
    // bit position of the last-transfer field in the configuration word
    localparam int CNT_LSB      = 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } xfer_size_e;
endpackage

// File: rtl/tbw_decode.sv
`timescale 1ns/1ps
module tbw_decode
    import tbw_pkg::*;
#(
    parameter int ADDR_W   = DEF_ADDR_W,
    parameter int IDX_W    = DEF_IDX_W,
    parameter int NUM_STUB = DEF_NUM_STUB,
    localparam int BANK_W  = $clog2(NUM_STUB),
    localparam int WORD_W  = ADDR_W - 2,
    localparam int SUM_W   = IDX_W + 1
) (
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic [IDX_W-1:0]  first_idx,
    input  logic [IDX_W-1:0]  xfer_idx,
    output logic              bank_sel,
    output logic [BANK_W-1:0] bank_idx,
    output logic              cfg_sel,
    output logic              buf_hit
);
    localparam logic [WORD_W-1:0] CFG_WORD = WORD_W'(NUM_STUB);
    localparam logic [WORD_W-1:0] BUF_WORD = WORD_W'(NUM_STUB + 1);
    localparam logic [SUM_W-1:0]  SUM_LIM  = SUM_W'(NUM_STUB);
    localparam logic [WORD_W-1:0] WRD_LIM  = WORD_W'(NUM_STUB);

    logic [WORD_W-1:0] word;
    logic [SUM_W-1:0]  tgt_sum;
    logic              word_ok;
    logic              buf_addr;
    logic              tgt_ok;
    xfer_size_e        sz;

    always_comb begin
        word     = addr[ADDR_W-1:2];
        sz       = xfer_size_e'(size);
        word_ok  = (sz == SZ_WORD) && (addr[1:0] == 2'b00);
        buf_addr = (word == BUF_WORD);
        tgt_sum  = {1'b0, first_idx} + {1'b0, xfer_idx};
        tgt_ok   = (tgt_sum < SUM_LIM);

        cfg_sel  = req && (word == CFG_WORD);
        buf_hit  = req && buf_addr && word_ok;

        if (buf_addr) begin
            bank_sel = buf_hit && tgt_ok;
            bank_idx = BANK_W'(tgt_sum);
        end else begin
            bank_sel = req && (word < WRD_LIM);
            bank_idx = BANK_W'(word);
        end
    end
endmodule

// File: rtl/tbw_xfer_ctrl.sv
`timescale 1ns/1ps
module tbw_xfer_ctrl
    import tbw_pkg::*;
#(
    parameter int IDX_W = DEF_IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_first_in,
    input  logic [IDX_W-1:0] cfg_last_in,
    input  logic             buf_hit,
    output logic [IDX_W-1:0] first_idx,
    output logic [IDX_W-1:0] last_idx,
    output logic [IDX_W-1:0] xfer_idx
);
    typedef struct packed {
        logic [IDX_W-1:0] first;
        logic [IDX_W-1:0] last;
        logic [IDX_W-1:0] idx;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            st_d.first = cfg_first_in;
            st_d.last  = cfg_last_in;
            st_d.idx   = '0;
        end else if (buf_hit) begin
            if (st_q.idx == st_q.last) begin
                st_d.idx = '0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign first_idx = st_q.first;
    assign last_idx  = st_q.last;
    assign xfer_idx  = st_q.idx;
endmodule

// File: rtl/tbw_stub_bank.sv
`timescale 1ns/1ps
module tbw_stub_bank
    import tbw_pkg::*;
#(
    parameter int NUM_STUB = DEF_NUM_STUB,
    parameter int TGT_W    = DEF_TGT_W,
    localparam int BANK_W  = $clog2(NUM_STUB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [BANK_W-1:0] idx,
    input  logic [TGT_W-1:0]  wdata,
    output logic [TGT_W-1:0]  rdata
);
    typedef struct packed {
        logic [NUM_STUB-1:0][TGT_W-1:0] regs;
    } bank_t;

    bank_t bk_d, bk_q;
    logic [NUM_STUB-1:0] wen;

    for (genvar g = 0; g < NUM_STUB; g++) begin : g_wen
        assign wen[g] = we && (idx == BANK_W'(g));
    end

    always_comb begin
        bk_d = bk_q;
        for (int i = 0; i < NUM_STUB; i++) begin
            if (wen[i]) begin
                bk_d.regs[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bk_q <= '0;
        end else begin
            bk_q <= bk_d;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_STUB; i++) begin
            if (idx == BANK_W'(i)) begin
                rdata = bk_q.regs[i];
            end
        end
    end
endmodule

// File: rtl/tmr_burst_win.sv
`timescale 1ns/1ps
module tmr_burst_win
    import tbw_pkg::*;
#(
    parameter int ADDR_W   = DEF_ADDR_W,
    parameter int DATA_W   = DEF_DATA_W,
    parameter int TGT_W    = DEF_TGT_W,
    parameter int IDX_W    = DEF_IDX_W,
    parameter int NUM_STUB = DEF_NUM_STUB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid
);
    localparam int BANK_W = $clog2(NUM_STUB);

    typedef struct packed {
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic              bank_sel;
    logic [BANK_W-1:0] bank_idx;
    logic              cfg_sel;
    logic              buf_hit;
    logic              cfg_we;
    logic              bank_we;
    logic [IDX_W-1:0]  cfg_first;
    logic [IDX_W-1:0]  cfg_last;
    logic [IDX_W-1:0]  xfer_idx;
    logic [TGT_W-1:0]  bank_rdata;
    logic [DATA_W-1:0] cfg_word;
    logic              unused_wbits;

    assign unused_wbits = ^bus_wdata[DATA_W-1:TGT_W];

    tbw_decode #(
        .ADDR_W   (ADDR_W),
        .IDX_W    (IDX_W),
        .NUM_STUB (NUM_STUB)
    ) u_decode (
        .req       (bus_req),
        .addr      (bus_addr),
        .size      (bus_size),
        .first_idx (cfg_first),
        .xfer_idx  (xfer_idx),
        .bank_sel  (bank_sel),
        .bank_idx  (bank_idx),
        .cfg_sel   (cfg_sel),
        .buf_hit   (buf_hit)
    );

    assign cfg_we  = cfg_sel && bus_we;
    assign bank_we = bank_sel && bus_we;

    tbw_xfer_ctrl #(
        .IDX_W (IDX_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_first_in (bus_wdata[IDX_W-1:0]),
        .cfg_last_in  (bus_wdata[CNT_LSB +: IDX_W]),
        .buf_hit      (buf_hit),
        .first_idx    (cfg_first),
        .last_idx     (cfg_last),
        .xfer_idx     (xfer_idx)
    );

    tbw_stub_bank #(
        .NUM_STUB (NUM_STUB),
        .TGT_W    (TGT_W)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bank_we),
        .idx   (bank_idx),
        .wdata (bus_wdata[TGT_W-1:0]),
        .rdata (bank_rdata)
    );

    always_comb begin
        cfg_word = '0;
        cfg_word[IDX_W-1:0]        = cfg_first;
        cfg_word[CNT_LSB +: IDX_W] = cfg_last;
    end

    always_comb begin
        rsp_d        = '0;
        rsp_d.rvalid = bus_req && !bus_we;
        if (bus_req && !bus_we) begin
            if (cfg_sel) begin
                rsp_d.rdata = cfg_word;
            end else if (bank_sel) begin
                rsp_d.rdata = {{(DATA_W-TGT_W){1'b0}}, bank_rdata};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign bus_rdata  = rsp_q.rdata;
    assign bus_rvalid = rsp_q.rvalid;
endmodule

// File: rtl/tbw_checker.sv
`timescale 1ns/1ps
module tbw_checker
    import tbw_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int TGT_W  = DEF_TGT_W,
    parameter int IDX_W  = DEF_IDX_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_rvalid,
    input logic              buf_hit,
    input logic              cfg_we,
    input logic [IDX_W-1:0]  cfg_last,
    input logic [IDX_W-1:0]  xfer_idx
);
    // R10: a read is answered in the next cycle
    a_r10_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |=> bus_rvalid);

    // R10: no response without a read
    a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && !bus_we) |=> !bus_rvalid);

    // R7: upper half of any response is zero
    a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> (bus_rdata[DATA_W-1:TGT_W] == '0));

    // R4: step by one inside the run
    a_r4_index_step: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_hit && !cfg_we && (xfer_idx != cfg_last)) |=> (xfer_idx == $past(xfer_idx) + 1'b1));

    // R4: wrap after the last transfer
    a_r4_index_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_hit && (xfer_idx == cfg_last)) |=> (xfer_idx == '0));

    // R5: configuration write clears the index
    a_r5_cfg_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (xfer_idx == '0));

    // R6: index holds without an accepted window access
    a_r6_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_hit && !cfg_we) |=> $stable(xfer_idx));

    // R4: index never passes the last-transfer index
    always_ff @(posedge clk) begin
        if (rst_n) begin
            a_r4_in_range: assert (xfer_idx <= cfg_last);
        end
    end
endmodule

bind tmr_burst_win tbw_checker #(
    .DATA_W (DATA_W),
    .TGT_W  (TGT_W),
    .IDX_W  (IDX_W)
) u_tbw_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .buf_hit    (buf_hit),
    .cfg_we     (cfg_we),
    .cfg_last   (cfg_last),
    .xfer_idx   (xfer_idx)
);

// File: tb/tmr_burst_win_bench.sv
`timescale 1ns/1ps
module tmr_burst_win_bench;
    localparam int NS = 18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;

    always #5 clk = ~clk;

    tmr_burst_win u_tmr_burst_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_size   (bus_size),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid)
    );

    int checks = 0;
    int errors = 0;
    bit run = 1'b0;
    bit done = 1'b0;

    // behavioural reference state
    logic [15:0] m_mem [NS];
    int          m_first = 0;
    int          m_last  = 0;
    int          m_idx   = 0;

    logic        nxt_v = 1'b0;
    logic [31:0] nxt_d = '0;
    string       nxt_tag = "R10";
    logic        exp_v = 1'b0;
    logic [31:0] exp_d = '0;
    string       exp_tag = "R10";

    always @(posedge clk) begin
        exp_v   = nxt_v;
        exp_d   = nxt_d;
        exp_tag = nxt_tag;
    end

    // compare against the model on every clock
    always @(negedge clk) begin
        if (run) begin
            #1;
            checks++;
            if (bus_rvalid !== exp_v || (exp_v && bus_rdata !== exp_d)) begin
                errors++;
                $display("FAIL %s: actual rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
                         exp_tag, bus_rvalid, bus_rdata, exp_v, exp_d);
            end
        end
    end

    task automatic access(input logic we, input logic [7:0] addr, input logic [1:0] sz,
                          input logic [31:0] wd, input string tag);
        int w;
        int t;
        logic [31:0] rd;
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = addr; bus_size = sz; bus_wdata = wd;
        w  = int'(addr >> 2);
        rd = '0;
        if (w < NS) begin
            if (we) m_mem[w] = wd[15:0];
            rd = {16'h0, m_mem[w]};
        end else if (w == NS) begin
            if (we) begin
                m_first = int'(wd[4:0]);
                m_last  = int'(wd[12:8]);
                m_idx   = 0;
            end
            rd = 32'(m_last * 256 + m_first);
        end else if (w == NS + 1) begin
            if (sz == 2'd2 && addr[1:0] == 2'b00) begin
                t = m_first + m_idx;
                if (t < NS) begin
                    rd = {16'h0, m_mem[t]};
                    if (we) m_mem[t] = wd[15:0];
                end
                m_idx = (m_idx == m_last) ? 0 : m_idx + 1;
            end
        end
        nxt_v   = !we;
        nxt_d   = rd;
        nxt_tag = tag;
    endtask

    task automatic idle();
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        nxt_v = 1'b0; nxt_d = '0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R10: watchdog expired, actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NS; i++) m_mem[i] = '0;
        repeat (3) @(posedge clk);
        #2;
        // R1: outputs quiet in reset
        checks++;
        if (bus_rvalid !== 1'b0 || bus_rdata !== 32'h0) begin
            errors++;
            $display("FAIL R1: actual rvalid=%0b rdata=%h expected rvalid=0 rdata=0", bus_rvalid, bus_rdata);
        end
        rst_n = 1'b1;
        run   = 1'b1;

        // R1: every mapped register reads zero after reset
        for (int i = 0; i < NS + 2; i++) access(1'b0, 8'(i * 4), 2'd2, 32'h0, "R1");
        access(1'b0, 8'h80, 2'd2, 32'h0, "R10");
        idle();

        // R9: direct stub access, upper write bits dropped
        for (int i = 0; i < NS; i++) access(1'b1, 8'(i * 4), 2'd2, {16'hDEAD, 16'(16'h1000 + i * 37)}, "R9");
        for (int i = 0; i < NS; i++) access(1'b0, 8'(i * 4), 2'd2, 32'h0, "R9");

        // R2: configuration fields and reserved bits
        access(1'b1, 8'h48, 2'd2, 32'hFFFF_E3E2, "R2");
        access(1'b0, 8'h48, 2'd2, 32'h0, "R2");

        // R3 and R4: two bursts of reads over 2..5
        for (int k = 0; k < 4; k++) access(1'b0, 8'h4C, 2'd2, 32'h0, "R3");
        for (int k = 0; k < 4; k++) access(1'b0, 8'h4C, 2'd2, 32'h0, "R4");
        idle();

        // R7: burst of writes, then direct read-back
        for (int k = 0; k < 4; k++) access(1'b1, 8'h4C, 2'd2, {16'hFFFF, 16'(16'h7700 + k)}, "R7");
        for (int i = 2; i < 6; i++) access(1'b0, 8'(i * 4), 2'd2, 32'h0, "R7");

        // R6: narrow and misaligned window accesses are ignored
        access(1'b0, 8'h4C, 2'd2, 32'h0, "R6");
        access(1'b0, 8'h4C, 2'd0, 32'h0, "R6");
        access(1'b1, 8'h4C, 2'd1, 32'h0000_5555, "R6");
        access(1'b1, 8'h4D, 2'd2, 32'h0000_6666, "R6");
        access(1'b0, 8'h4E, 2'd2, 32'h0, "R6");
        access(1'b0, 8'h4C, 2'd2, 32'h0, "R6");
        access(1'b0, 8'h0C, 2'd2, 32'h0, "R6");

        // R5: configuration write mid-burst restarts at the first register
        access(1'b0, 8'h4C, 2'd2, 32'h0, "R5");
        access(1'b1, 8'h48, 2'd2, 32'h0000_0207, "R5");
        access(1'b0, 8'h4C, 2'd2, 32'h0, "R5");
        access(1'b0, 8'h4C, 2'd2, 32'h0, "R5");
        idle();

        // R8: run crossing the end of the bank, wrap on a dropped access
        access(1'b1, 8'h48, 2'd2, 32'h0000_0410, "R8");
        for (int k = 0; k < 5; k++) access(1'b1, 8'h4C, 2'd2, 32'(32'h0000_BE00 + k), "R8");
        access(1'b0, 8'h40, 2'd2, 32'h0, "R8");
        access(1'b0, 8'h44, 2'd2, 32'h0, "R8");
        access(1'b0, 8'h48, 2'd2, 32'h0, "R8");
        for (int k = 0; k < 6; k++) access(1'b0, 8'h4C, 2'd2, 32'h0, "R8");

        // R8: every target out of range, full 32-step run and wrap
        access(1'b1, 8'h48, 2'd2, 32'h0000_1F1F, "R8");
        for (int k = 0; k < 33; k++) access(1'b1, 8'h4C, 2'd2, 32'h0000_4242, "R8");
        for (int k = 0; k < 33; k++) access(1'b0, 8'h4C, 2'd2, 32'h0, "R8");
        access(1'b0, 8'h48, 2'd2, 32'h0, "R8");
        for (int i = 0; i < NS; i++) access(1'b0, 8'(i * 4), 2'd2, 32'h0, "R8");

        // R10: unmapped read after writes
        access(1'b0, 8'hFC, 2'd2, 32'h0, "R10");
        repeat (3) idle();

        run  = 1'b0;
        done = 1'b1;
        summary();
        $finish;
    end
endmodule